// File: doc/BRIEF.md
# Receive Descriptor Ring Completion Unit

This unit closes out received frames against a ring of receive descriptors kept in a word-addressed memory. Each descriptor is three consecutive words. The link to the next descriptor sits at offset 0, the command/status word at offset 1, and the buffer pointer at offset 2. Software owns a descriptor while bit 31 of its status word is clear. The unit takes ownership back by setting that bit once it has written the frame's size and error flags.

The unit starts idle after reset, with its current-descriptor pointer at a parameterised ring base. An RX-on command makes it fetch the status word of the current descriptor. If software owns that descriptor, the unit becomes ready for a frame-end event. If the descriptor is still marked as completed, the unit parks idle until the next RX-on.

For each frame-end event the unit does three things in order:
1. It reads the link word.
2. It writes the status word.
3. It moves to the linked descriptor.

An RX-off command lets a write-back that has already started finish, and then leaves the unit idle. The buffer data movement is handled elsewhere.

Top module: `rx_ring_completer`

## Requirements
- R1: After reset the unit is idle. `rx_ready` is low and there are no memory reads or writes until an RX-on command arrives.
- R2: An RX-on command while idle causes a read of the current descriptor's status word (address pointer+1). If bit 31 of that word is clear, `rx_ready` goes high.
- R3: A completion writes the status word as follows. Bit 31 is set to 1. Bit 30 takes `fe_more`. Bit 29 keeps the value software left there. Bit 28 and bits 15:12 are zero. Bits 11:0 take `fe_len` (the byte count including CRC). `fe_flags[10:0]` go to bits 26:16: abort=26, overrun=25, destination class=24:23, too long=22, runt=21, invalid symbol=20, CRC=19, alignment=18, loopback=17, collision=16.
- R4: Status bit 27 (good packet) is set only when `fe_more` is clear and none of abort, overrun, too long, runt, invalid symbol, CRC or alignment is flagged. Destination class, loopback and collision do not affect it.
- R5: A completion writes only the status word (pointer+1), exactly once, and only after reading the link word (pointer+0). The link and buffer words are left unchanged.
- R6: After a completion the pointer becomes the link word just read. A four-descriptor ring whose last link points at the first one wraps to the first descriptor.
- R7: If the next descriptor's status bit 31 is already set, the unit goes idle with `rx_ready` low. Frame-end events are then ignored and no memory write occurs.
- R8: After software clears bit 31 of the parked descriptor and issues RX-on, the next frame completes into that same descriptor.
- R9: An RX-off command during a write-back lets the status write complete, then leaves the unit idle. Later frame-end events are ignored until RX-on, after which the unit resumes at the next descriptor.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_on | input | 1 | One-cycle command to start or resume reception |
| rx_off | input | 1 | One-cycle command to stop reception |
| fe_valid | input | 1 | Frame-end event strobe |
| fe_len | input | 12 | Received byte count including CRC |
| fe_more | input | 1 | Frame continues in a further descriptor |
| fe_flags | input | 11 | Receive flags, placed at status bits 26:16 |
| rx_ready | output | 1 | Unit holds a software-owned descriptor and accepts a frame end |
| mem_addr | output | AW | Word address of the descriptor memory access |
| mem_re | output | 1 | Read strobe; data returns on `mem_rdata` one cycle later |
| mem_we | output | 1 | Write strobe |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data |

## Verification
The assertions assume a memory that returns read data exactly one cycle after `mem_re` and completes a write in the cycle it is strobed. They also assume that descriptor words are changed only by software while the unit is idle. The bench's memory model meets the first assumption. The bench meets the second by editing descriptors only while the ring is parked or before RX-on. It drives `fe_valid` for one cycle, normally only while `rx_ready` is high. The exceptions are deliberate probes of the ignore behaviour in the parked and stopped states.

// File: rtl/rx_ring_completer.sv
module rx_ring_completer #(
  parameter int AW        = 16,
  parameter int RING_BASE = 0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rx_on,
  input  logic          rx_off,
  input  logic          fe_valid,
  input  logic [11:0]   fe_len,
  input  logic          fe_more,
  input  logic [10:0]   fe_flags,
  output logic          rx_ready,
  output logic [AW-1:0] mem_addr,
  output logic          mem_re,
  output logic          mem_we,
  output logic [31:0]   mem_wdata,
  input  logic [31:0]   mem_rdata
);
  localparam logic [AW-1:0] LINK_OFS = AW'(0);
  localparam logic [AW-1:0] STAT_OFS = AW'(1);
  localparam logic [10:0]   ERR_MASK = 11'b110_0111_1100;

  typedef enum logic [2:0] {S_OFF, S_CHK, S_CHKW, S_RDY, S_LNK, S_LNKW, S_WR} st_t;
  st_t st;

  logic [AW-1:0] cur, nxt;
  logic          keep_intr, stop_pend;
  logic [11:0]   l_len;
  logic          l_more;
  logic [10:0]   l_flags;
  logic          good;

  assign good      = !l_more && ((l_flags & ERR_MASK) == 11'd0);
  assign rx_ready  = (st == S_RDY);
  assign mem_re    = (st == S_CHK) || (st == S_LNK);
  assign mem_we    = (st == S_WR);
  assign mem_addr  = cur + ((st == S_LNK) ? LINK_OFS : STAT_OFS);
  assign mem_wdata = {1'b1, l_more, keep_intr, 1'b0, good, l_flags, 4'b0, l_len};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= S_OFF;
      cur       <= AW'(RING_BASE);
      nxt       <= '0;
      keep_intr <= 1'b0;
      stop_pend <= 1'b0;
      l_len     <= '0;
      l_more    <= 1'b0;
      l_flags   <= '0;
    end else begin
      case (st)
        S_OFF:  if (rx_on && !rx_off) st <= S_CHK;
        S_CHK:  st <= rx_off ? S_OFF : S_CHKW;
        S_CHKW: begin
          keep_intr <= mem_rdata[29];
          if (rx_off || mem_rdata[31]) st <= S_OFF;
          else                         st <= S_RDY;
        end
        S_RDY: begin
          if (rx_off) st <= S_OFF;
          else if (fe_valid) begin
            l_len   <= fe_len;
            l_more  <= fe_more;
            l_flags <= fe_flags;
            st      <= S_LNK;
          end
        end
        S_LNK: begin
          if (rx_off) stop_pend <= 1'b1;
          st <= S_LNKW;
        end
        S_LNKW: begin
          if (rx_off) stop_pend <= 1'b1;
          nxt <= mem_rdata[AW-1:0];
          st  <= S_WR;
        end
        S_WR: begin
          cur       <= nxt;
          stop_pend <= 1'b0;
          st        <= (stop_pend || rx_off) ? S_OFF : S_CHK;
        end
        default: st <= S_OFF;
      endcase
    end
  end

  a_r5_status_after_link: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> ($past(mem_re, 2) && mem_addr == $past(mem_addr, 2) + STAT_OFS));
  a_r5_single_write: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |=> !mem_we);
  a_r3_own_set: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (mem_wdata[31] && !mem_wdata[28] && mem_wdata[15:12] == 4'd0));
  a_r4_good_rule: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (mem_wdata[27] == (!mem_wdata[30] && mem_wdata[26:25] == 2'd0
                                  && mem_wdata[22:18] == 5'd0)));
  a_r1_no_rw_clash: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_we && mem_re));
  a_r7_ready_after_fetch: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_ready) |-> $past(mem_re, 2) && !$past(mem_rdata[31]));
endmodule

// File: tb/rx_ring_completer_tb_top.sv
module rx_ring_completer_tb_top;
  logic clk = 0, rst_n = 0;
  logic rx_on = 0, rx_off = 0, fe_valid = 0, fe_more = 0;
  logic [11:0] fe_len = 0;
  logic [10:0] fe_flags = 0;
  logic rx_ready, mem_re, mem_we;
  logic [15:0] mem_addr;
  logic [31:0] mem_wdata, mem_rdata;
  logic [31:0] mem [64];
  int checks = 0, fails = 0, acc = 0;

  always #5 clk = ~clk;

  rx_ring_completer #(.AW(16), .RING_BASE(0)) dut_i (
    .clk(clk), .rst_n(rst_n), .rx_on(rx_on), .rx_off(rx_off),
    .fe_valid(fe_valid), .fe_len(fe_len), .fe_more(fe_more), .fe_flags(fe_flags),
    .rx_ready(rx_ready), .mem_addr(mem_addr), .mem_re(mem_re), .mem_we(mem_we),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata));

  always_ff @(posedge clk) begin
    if (mem_re) mem_rdata <= mem[mem_addr[5:0]];
    if (mem_we) mem[mem_addr[5:0]] <= mem_wdata;
  end
  always @(posedge clk) if (rst_n && (mem_re || mem_we)) acc++;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] expst(logic [11:0] len, logic more, logic [10:0] fl, logic intr);
    logic ok;
    ok = !more && ((fl & 11'h67C) == 0);
    return {1'b1, more, intr, 1'b0, ok, fl, 4'b0, len};
  endfunction

  task automatic pulse_on();
    @(negedge clk) rx_on = 1; @(negedge clk) rx_on = 0;
    repeat (4) @(negedge clk);
  endtask

  task automatic frame(logic [11:0] len, logic more, logic [10:0] fl, bit stop);
    @(negedge clk);
    fe_len = len; fe_more = more; fe_flags = fl; fe_valid = 1;
    @(negedge clk) fe_valid = 0;
    if (stop) begin rx_off = 1; @(negedge clk) rx_off = 0; end
    repeat (8) @(negedge clk);
  endtask

  task automatic t_reset();
    repeat (6) @(negedge clk);
    chk("R1 ready after reset", {31'b0, rx_ready}, 0);
    chk("R1 no access before rx_on", acc, 0);
  endtask

  task automatic t_start();
    for (int i = 0; i < 4; i++) begin
      mem[4*i]   = 32'(4*((i+1)%4));
      mem[4*i+1] = (i == 1) ? 32'h2000_0600 : 32'h0000_0600;
      mem[4*i+2] = 32'h100 * i;
    end
    pulse_on();
    chk("R2 ready after rx_on", {31'b0, rx_ready}, 1);
  endtask

  task automatic t_ring();
    frame(12'd64, 0, 11'h000, 0);
    chk("R4 clean frame", mem[1], expst(12'd64, 0, 0, 0));
    chk("R5 link untouched", mem[0], 4);
    chk("R5 buffer untouched", mem[2], 0);
    frame(12'd100, 0, 11'h008, 0);
    chk("R3 crc + intr kept desc1", mem[5], expst(12'd100, 0, 11'h008, 1));
    frame(12'd1518, 1, 11'h181, 0);
    chk("R4 more clears good desc2", mem[9], expst(12'd1518, 1, 11'h181, 0));
    frame(12'd77, 0, 11'h002, 0);
    chk("R6 desc3 loopback good", mem[13], expst(12'd77, 0, 11'h002, 0));
    chk("R5 desc3 buffer", mem[14], 32'h300);
  endtask

  task automatic t_stall();
    int a0;
    chk("R7 parked not ready", {31'b0, rx_ready}, 0);
    a0 = acc;
    frame(12'd50, 0, 0, 0);
    chk("R7 ignored frame no access", acc, a0);
    chk("R7 desc0 unchanged", mem[1], expst(12'd64, 0, 0, 0));
    mem[1] = 32'h2000_0600;
    pulse_on();
    chk("R8 ready after rearm", {31'b0, rx_ready}, 1);
    frame(12'd200, 0, 11'h400, 0);
    chk("R8 R6 wrap into desc0", mem[1], expst(12'd200, 0, 11'h400, 1));
  endtask

  task automatic t_stop();
    mem[5] = 32'h0000_0600; mem[9] = 32'h0000_0600;
    pulse_on();
    chk("R9 ready before stop", {31'b0, rx_ready}, 1);
    frame(12'd300, 0, 11'h020, 1);
    chk("R9 write-back completed", mem[5], expst(12'd300, 0, 11'h020, 0));
    chk("R9 idle after stop", {31'b0, rx_ready}, 0);
    frame(12'd33, 0, 0, 0);
    chk("R9 frame ignored while stopped", mem[9], 32'h0000_0600);
    pulse_on();
    frame(12'd90, 0, 0, 0);
    chk("R9 resumes at desc2", mem[9], expst(12'd90, 0, 0, 0));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_start();
    t_ring();
    t_stall();
    t_stop();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule